// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a simple register port and a flash physical controller. Software loads a start word address, then writes a command word that selects the operation, gives the word count minus one and sets a launch bit. The sequencer then drives one request per flash word toward the physical side. Reads land in a read FIFO that software drains. Programs take their data from a program FIFO that software fills. An erase of a page or a whole bank goes out as a single request.

Long reads are throttled by the read FIFO. The engine stops issuing words when the FIFO holds as many words as its limit allows, and it continues once software pops a word. Six sticky status bits record FIFO conditions, completion and rejected launches. Each bit drives an interrupt line through its own enable.

Top module: `nvm_op_sequencer`

## Requirements
- R1: Register 0 is the command word: bit 0 launches (self-clearing, never stored), bits [2:1] select the operation (0 read, 1 program, 2 page erase, 3 bank erase), and bits [15:8] hold the word count minus one. While a request is out, exactly one of the four operation flags is high.
- R2: Register 1 holds the start word address. Each completed word advances the request address by one. No page boundary is checked, so a burst may run across one.
- R3: Each read word returned is pushed into the read FIFO. A register read of address 6 pops the words in address order.
- R4: A read issues a new word only while the read FIFO count is below its limit. The limit is the read level when that level is nonzero and no larger than the depth, and the FIFO depth otherwise. Issuing resumes after a pop.
- R5: Data written to register 5 is queued in the program FIFO. Each program word carries the FIFO head as its data. While that FIFO is empty, the request stays low.
- R6: A page or bank erase issues exactly one request, at the start address, whatever the count field holds.
- R7: After the done response of the final word, status bit 4 (operation done) becomes set.
- R8: A launch while an operation runs, or while the physical side reports init busy, starts nothing and sets status bit 4+1 (bit 5). A running operation continues unchanged.
- R9: Status (register 2) is sticky, and writing 1 to a bit clears it. Bit 0 means the program FIFO is empty, bit 1 means the program count is at or below the program level, bit 2 means the read FIFO is full, bit 3 means the read count is at or above a nonzero read level, and bits 4 and 5 are as in R7 and R8.
- R10: irq_o equals the status bits ANDed with the enable register (register 3).
- R11: Register 4 holds the program level in bits [2:0] and the read level in bits [5:3], and reads back as written.
- R12: After reset no request is out, irq_o is zero and the status reads 6'b000011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops read FIFO at address 6) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 6 | Masked interrupt lines, one per status bit |
| phy_req_o | output | 1 | Word request to the physical controller |
| phy_addr_o | output | 16 | Word address of the request |
| phy_rd_o | output | 1 | Request is a read |
| phy_prog_o | output | 1 | Request is a program |
| phy_pg_erase_o | output | 1 | Request is a page erase |
| phy_bk_erase_o | output | 1 | Request is a bank erase |
| phy_wdata_o | output | 32 | Program data word |
| phy_rd_done_i | input | 1 | Read word completed |
| phy_prog_done_i | input | 1 | Program word completed |
| phy_erase_done_i | input | 1 | Erase completed |
| phy_init_busy_i | input | 1 | Physical side still initialising |
| phy_rdata_i | input | 32 | Read data, valid with read done |

## Verification
A register write takes effect at the next edge. The request for a word goes high in that same cycle or as soon as FIFO room or data permits. A done pulse moves the address, the FIFO and the status at the following edge. The bench model of the physical side answers a fixed number of cycles after it sees a request and records each answered word. The bench then waits a generous, fixed window before it compares the record, the FIFO data or the status. It samples at the falling edge, so every result it reads has settled at least half a cycle earlier.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_PGER = 2'd2,
    OP_BKER = 2'd3
  } nvm_op_e;

  localparam logic [2:0] RA_CMD   = 3'd0;
  localparam logic [2:0] RA_ADDR  = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_EN    = 3'd3;
  localparam logic [2:0] RA_LVL   = 3'd4;
  localparam logic [2:0] RA_WDATA = 3'd5;
  localparam logic [2:0] RA_RDATA = 3'd6;

  localparam int unsigned NIRQ     = 6;
  localparam int unsigned IRQ_PEMP = 0;
  localparam int unsigned IRQ_PLVL = 1;
  localparam int unsigned IRQ_RFUL = 2;
  localparam int unsigned IRQ_RLVL = 3;
  localparam int unsigned IRQ_DONE = 4;
  localparam int unsigned IRQ_ERR  = 5;
endpackage

// File: rtl/nvm_seq_fifo.sv
module nvm_seq_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rdata_o,
  output logic [CNTW-1:0] count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  always_comb begin
    push_ok = push_i && (cnt_q != CNTW'(DEPTH));
    pop_ok  = pop_i && (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_q];
  assign count_o = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DEPTH));
  p_cnt_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/nvm_seq_core.sv
module nvm_seq_core
  import nvm_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  nvm_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          can_read_i,
  input  logic          prog_avail_i,
  input  logic [DW-1:0] prog_word_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          push_rd_o,
  output logic          pop_prog_o,
  output logic          phy_req_o,
  output logic [AW-1:0] phy_addr_o,
  output logic          phy_rd_o,
  output logic          phy_prog_o,
  output logic          phy_pg_erase_o,
  output logic          phy_bk_erase_o,
  output logic [DW-1:0] phy_wdata_o,
  input  logic          phy_rd_done_i,
  input  logic          phy_prog_done_i,
  input  logic          phy_erase_done_i
);
  logic          busy_q, busy_d, held_q, held_d;
  nvm_op_e       op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          ready, match_done, word_done, last, req;

  always_comb begin
    unique case (op_q)
      OP_READ: begin ready = can_read_i;   match_done = phy_rd_done_i;   end
      OP_PROG: begin ready = prog_avail_i; match_done = phy_prog_done_i; end
      default: begin ready = 1'b1;         match_done = phy_erase_done_i; end
    endcase
    req       = busy_q && (held_q || ready);
    word_done = req && match_done;
    last      = (op_q == OP_PGER) || (op_q == OP_BKER) || (rem_q == '0);

    busy_d = busy_q;
    held_d = held_q;
    op_d   = op_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (launch_i) begin
      busy_d = 1'b1;
      held_d = 1'b0;
      op_d   = op_i;
      addr_d = addr_i;
      rem_d  = cnt_i;
    end else if (word_done) begin
      held_d = 1'b0;
      addr_d = addr_q + 1'b1;
      rem_d  = rem_q - 1'b1;
      if (last) busy_d = 1'b0;
    end else if (req) begin
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      held_q <= 1'b0;
      op_q   <= OP_READ;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      busy_q <= busy_d;
      held_q <= held_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign busy_o         = busy_q;
  assign done_o         = word_done && last;
  assign push_rd_o      = word_done && (op_q == OP_READ);
  assign pop_prog_o     = word_done && (op_q == OP_PROG);
  assign phy_req_o      = req;
  assign phy_addr_o     = addr_q;
  assign phy_rd_o       = req && (op_q == OP_READ);
  assign phy_prog_o     = req && (op_q == OP_PROG);
  assign phy_pg_erase_o = req && (op_q == OP_PGER);
  assign phy_bk_erase_o = req && (op_q == OP_BKER);
  assign phy_wdata_o    = prog_word_i;

  p_one_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> $onehot({phy_rd_o, phy_prog_o, phy_pg_erase_o, phy_bk_erase_o}));
  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && !last) |=> (phy_addr_o == $past(phy_addr_o) + 1'b1));
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && !word_done) |=> (phy_req_o && $stable(phy_addr_o)));
  p_req_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> busy_q);
endmodule

// File: rtl/nvm_op_sequencer.sv
module nvm_op_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [NIRQ-1:0] irq_o,
  output logic            phy_req_o,
  output logic [AW-1:0]   phy_addr_o,
  output logic            phy_rd_o,
  output logic            phy_prog_o,
  output logic            phy_pg_erase_o,
  output logic            phy_bk_erase_o,
  output logic [DW-1:0]   phy_wdata_o,
  input  logic            phy_rd_done_i,
  input  logic            phy_prog_done_i,
  input  logic            phy_erase_done_i,
  input  logic            phy_init_busy_i,
  input  logic [DW-1:0]   phy_rdata_i
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [AW-1:0]   sw_addr_q, sw_addr_d;
  logic [NIRQ-1:0] en_q, en_d, stat_q, stat_d, stat_set, stat_clr;
  logic [LW-1:0]   plvl_q, plvl_d, rlvl_q, rlvl_d, rlim;
  logic [LW-1:0]   pcnt, rcnt;
  logic [DW-1:0]   pword, rword;
  logic            start_wr, launch, reject, busy, op_done, rd_push, prog_pop;

  always_comb begin
    start_wr = reg_we_i && (reg_addr_i == RA_CMD) && reg_wdata_i[0];
    launch   = start_wr && !busy && !phy_init_busy_i;
    reject   = start_wr && (busy || phy_init_busy_i);
    rlim     = ((rlvl_q == '0) || (rlvl_q > LW'(DEPTH))) ? LW'(DEPTH) : rlvl_q;

    stat_set           = '0;
    stat_set[IRQ_PEMP] = (pcnt == '0);
    stat_set[IRQ_PLVL] = (pcnt <= plvl_q);
    stat_set[IRQ_RFUL] = (rcnt == LW'(DEPTH));
    stat_set[IRQ_RLVL] = (rlvl_q != '0) && (rcnt >= rlvl_q);
    stat_set[IRQ_DONE] = op_done;
    stat_set[IRQ_ERR]  = reject;
    stat_clr = (reg_we_i && (reg_addr_i == RA_STAT)) ? reg_wdata_i[NIRQ-1:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;

    sw_addr_d = sw_addr_q;
    en_d      = en_q;
    plvl_d    = plvl_q;
    rlvl_d    = rlvl_q;
    if (reg_we_i) begin
      unique case (reg_addr_i)
        RA_ADDR: sw_addr_d = reg_wdata_i[AW-1:0];
        RA_EN:   en_d      = reg_wdata_i[NIRQ-1:0];
        RA_LVL: begin
          plvl_d = reg_wdata_i[LW-1:0];
          rlvl_d = reg_wdata_i[2*LW-1:LW];
        end
        default: ;
      endcase
    end

    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_ADDR:  reg_rdata_o = DW'(sw_addr_q);
      RA_STAT:  reg_rdata_o = DW'(stat_q);
      RA_EN:    reg_rdata_o = DW'(en_q);
      RA_LVL:   reg_rdata_o = DW'({rlvl_q, plvl_q});
      RA_RDATA: reg_rdata_o = rword;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_addr_q <= '0;
      en_q      <= '0;
      stat_q    <= '0;
      plvl_q    <= '0;
      rlvl_q    <= '0;
    end else begin
      sw_addr_q <= sw_addr_d;
      en_q      <= en_d;
      stat_q    <= stat_d;
      plvl_q    <= plvl_d;
      rlvl_q    <= rlvl_d;
    end
  end

  assign irq_o = stat_q & en_q;

  nvm_seq_fifo #(.DW(DW), .DEPTH(DEPTH), .CNTW(LW)) u_prog_fifo (
    .clk_i, .rst_ni,
    .push_i  (reg_we_i && (reg_addr_i == RA_WDATA)),
    .wdata_i (reg_wdata_i),
    .pop_i   (prog_pop),
    .rdata_o (pword),
    .count_o (pcnt)
  );

  nvm_seq_fifo #(.DW(DW), .DEPTH(DEPTH), .CNTW(LW)) u_rd_fifo (
    .clk_i, .rst_ni,
    .push_i  (rd_push),
    .wdata_i (phy_rdata_i),
    .pop_i   (reg_re_i && (reg_addr_i == RA_RDATA)),
    .rdata_o (rword),
    .count_o (rcnt)
  );

  nvm_seq_core #(.AW(AW), .CW(CW), .DW(DW)) u_core (
    .clk_i, .rst_ni,
    .launch_i     (launch),
    .op_i         (nvm_op_e'(reg_wdata_i[2:1])),
    .addr_i       (sw_addr_q),
    .cnt_i        (reg_wdata_i[8 +: CW]),
    .can_read_i   (rcnt < rlim),
    .prog_avail_i (pcnt != '0),
    .prog_word_i  (pword),
    .busy_o       (busy),
    .done_o       (op_done),
    .push_rd_o    (rd_push),
    .pop_prog_o   (prog_pop),
    .phy_req_o, .phy_addr_o, .phy_rd_o, .phy_prog_o,
    .phy_pg_erase_o, .phy_bk_erase_o, .phy_wdata_o,
    .phy_rd_done_i, .phy_prog_done_i, .phy_erase_done_i
  );

  p_rd_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_push |-> (rcnt < LW'(DEPTH)));
  p_done_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done |=> stat_q[IRQ_DONE]);
  p_reject_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> stat_q[IRQ_ERR]);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_addr_i == RA_STAT) && reg_wdata_i[IRQ_DONE] && !op_done)
      |=> !stat_q[IRQ_DONE]);
endmodule

// File: tb/nvm_op_sequencer_tb.sv
module nvm_op_sequencer_tb;
  localparam int DEPTH = 4;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, we, re, init_busy;
  logic [2:0]  ra;
  logic [31:0] wd, rdat, p_rdata;
  logic [5:0]  irq;
  logic        p_req, p_rd, p_prog, p_pg, p_bk;
  logic [15:0] p_addr;
  logic [31:0] p_wdata;
  logic        d_rd, d_pr, d_er;

  nvm_op_sequencer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdat), .irq_o(irq),
    .phy_req_o(p_req), .phy_addr_o(p_addr), .phy_rd_o(p_rd), .phy_prog_o(p_prog),
    .phy_pg_erase_o(p_pg), .phy_bk_erase_o(p_bk), .phy_wdata_o(p_wdata),
    .phy_rd_done_i(d_rd), .phy_prog_done_i(d_pr), .phy_erase_done_i(d_er),
    .phy_init_busy_i(init_busy), .phy_rdata_i(p_rdata)
  );

  int n_chk = 0, n_fail = 0, lg_n = 0, lat = 0;
  logic fin = 1'b0;
  logic [15:0] lg_addr [64];
  int          lg_kind [64];
  logic [31:0] lg_data [64];

  function automatic logic [31:0] rd_pat(logic [15:0] a);
    return 32'h1000_0000 + 32'(a) * 7;
  endfunction

  // physical controller model: answers LAT cycles after a request
  always @(negedge clk) begin
    if (!rst_n) begin
      d_rd <= 1'b0; d_pr <= 1'b0; d_er <= 1'b0; lat <= 0; p_rdata <= '0;
    end else if (d_rd || d_pr || d_er) begin
      d_rd <= 1'b0; d_pr <= 1'b0; d_er <= 1'b0; lat <= 0;
    end else if (p_req) begin
      if (lat == LAT - 1) begin
        d_rd <= p_rd; d_pr <= p_prog; d_er <= p_pg | p_bk;
        p_rdata <= rd_pat(p_addr);
        if (lg_n < 64) begin
          lg_addr[lg_n] <= p_addr;
          lg_kind[lg_n] <= p_rd ? 0 : p_prog ? 1 : p_pg ? 2 : 3;
          lg_data[lg_n] <= p_wdata;
          lg_n <= lg_n + 1;
        end
        lat <= 0;
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; ra = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    re = 1'b1; ra = a;
    #1 d = rdat;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic do_read(logic [15:0] base, int n, int lim, bit inject);
    int s = lg_n;
    int first = (n < lim) ? n : lim;
    logic [31:0] d;
    wr(3'd1, 32'(base));
    wr(3'd0, 32'((n - 1) << 8) | 32'h1);
    if (inject) begin
      wr(3'd0, 32'h0000_0303);
      rd(3'd2, d);
      check("R8 launch while busy sets error", 32'(d[5]), 32'd1);
    end
    repeat (40) @(negedge clk);
    check("R4 reads issued before first pop", 32'(lg_n - s), 32'(first));
    rd(3'd2, d);
    if (lim == DEPTH && n >= DEPTH) check("R9 read full flag", 32'(d[2]), 32'd1);
    if (lim < DEPTH && n >= lim)    check("R9 read level flag", 32'(d[3]), 32'd1);
    for (int i = 0; i < n; i++) begin
      repeat (12) @(negedge clk);
      rd(3'd6, d);
      check("R3 read word in order", d, rd_pat(base + 16'(i)));
    end
    repeat (10) @(negedge clk);
    rd(3'd2, d);
    check("R7 done after read", 32'(d[4]), 32'd1);
    check("R2 read word count", 32'(lg_n - s), 32'(n));
    for (int i = 0; i < n; i++) begin
      check("R2 read address", 32'(lg_addr[s + i]), 32'(base + 16'(i)));
      check("R1 read flag", 32'(lg_kind[s + i]), 32'd0);
    end
    wr(3'd2, 32'h3F);
  endtask

  task automatic do_prog(logic [15:0] base, int n);
    int s = lg_n;
    int k = (n < DEPTH) ? n : DEPTH;
    logic [31:0] d;
    for (int i = 0; i < k; i++) wr(3'd5, {16'hC0DE, base + 16'(i)});
    wr(3'd1, 32'(base));
    wr(3'd0, 32'((n - 1) << 8) | 32'h3);
    repeat (40) @(negedge clk);
    check("R5 words programmed from queued data", 32'(lg_n - s), 32'(k));
    if (n > k) check("R5 request low while program FIFO empty", 32'(p_req), 32'd0);
    for (int i = k; i < n; i++) wr(3'd5, {16'hC0DE, base + 16'(i)});
    repeat (40) @(negedge clk);
    rd(3'd2, d);
    check("R7 done after program", 32'(d[4]), 32'd1);
    check("R5 program word count", 32'(lg_n - s), 32'(n));
    for (int i = 0; i < n; i++) begin
      check("R2 program address", 32'(lg_addr[s + i]), 32'(base + 16'(i)));
      check("R1 program flag", 32'(lg_kind[s + i]), 32'd1);
      check("R5 program data", lg_data[s + i], {16'hC0DE, base + 16'(i)});
    end
    wr(3'd2, 32'h3F);
  endtask

  task automatic do_erase(int op, logic [15:0] base);
    int s = lg_n;
    logic [31:0] d;
    wr(3'd1, 32'(base));
    wr(3'd0, 32'h0000_0701 | 32'(op << 1));
    repeat (30) @(negedge clk);
    check("R6 erase issues one request", 32'(lg_n - s), 32'd1);
    check("R6 erase address", 32'(lg_addr[s]), 32'(base));
    check("R1 erase kind", 32'(lg_kind[s]), 32'(op));
    rd(3'd2, d);
    check("R7 done after erase", 32'(d[4]), 32'd1);
  endtask

  initial begin
    logic [31:0] d;
    int s;
    rst_n = 1'b0; we = 1'b0; re = 1'b0; ra = '0; wd = '0; init_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 no request after reset", 32'(p_req), 32'd0);
    check("R12 irq zero after reset", 32'(irq), 32'd0);
    rd(3'd2, d);
    check("R12 status after reset", d, 32'h3);

    init_busy = 1'b1;
    s = lg_n;
    wr(3'd0, 32'h1);
    repeat (10) @(negedge clk);
    rd(3'd2, d);
    check("R8 launch during init busy sets error", 32'(d[5]), 32'd1);
    check("R8 no request during init busy", 32'(lg_n - s), 32'd0);
    wr(3'd2, 32'h20);
    rd(3'd2, d);
    check("R9 write one clears error", 32'(d[5]), 32'd0);
    init_busy = 1'b0;

    for (int n = 1; n <= 6; n++) do_read(16'(n * 16'h40), n, DEPTH, 1'b0);

    wr(3'd4, 32'h15);
    rd(3'd4, d);
    check("R11 level register readback", d, 32'h15);
    do_read(16'h0200, 5, 2, 1'b0);
    wr(3'd4, 32'h0);

    for (int n = 1; n <= 5; n++) do_prog(16'(16'h00FE + n * 16'h100), n);

    do_erase(2, 16'h1234);
    do_erase(3, 16'h4321);
    wr(3'd2, 32'h3F);

    do_read(16'h0300, 6, DEPTH, 1'b1);

    wr(3'd3, 32'h10);
    do_erase(3, 16'h0777);
    check("R10 irq shows enabled done only", 32'(irq), 32'h10);
    wr(3'd3, 32'h0);
    check("R10 irq masked when disabled", 32'(irq), 32'h0);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule